// File: doc/BRIEF.md
# Extended-Precision Mantissa Rounding Unit

This block takes one unpacked floating-point operand per transfer and rounds its significand to a selected target width under a selected rounding direction. The operand carries a sign, an unbiased signed exponent, an 83-bit mantissa and a sticky flag. The mantissa holds an explicit leading one at bit 82, an 80-bit fraction, and two extra low bits (guard and round). A class code marks ordinary numbers apart from zero, infinity and NaN.

Before rounding, an optional right-shift stage moves the mantissa down by a requested amount. Every nonzero bit pushed off the bottom is folded into sticky. The rounder then clears all bits below the target LSB and adds one LSB when the mode and the discarded bits call for it. A carry out of the top bit renormalises the mantissa to 1.0 and bumps the exponent. The output also reports whether any information was lost.

Results are held in one output register behind a valid/ready handshake, with one cycle of latency.

Top module: `rnd_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0.
- R2: in_ready is high exactly when the output register is empty or out_ready is high. An accepted input gives out_valid one clock later. While out_valid is high and out_ready is low, the outputs hold their values, and a new input is not taken.
- R3: Precision is in_ctrl[7:6]: 00 extended (64 significand bits, LSB at mantissa bit 19), 01 single (24 bits, LSB at bit 59), 10 double (53 bits, LSB at bit 30), 11 treated as extended. For a number, every output mantissa bit below the target LSB is 0.
- R4: Rounding mode is in_ctrl[5:4], and 00 is round to nearest. In that mode, a discarded part above half an LSB rounds up. A discarded part of exactly half with sticky clear rounds to the even kept value.
- R5: Mode 01 (toward zero) always truncates.
- R6: Mode 10 (toward minus infinity) adds one LSB only for a negative sign with a nonzero discarded part. Mode 11 (toward plus infinity) does so only for a positive sign.
- R7: A round-up that carries out of bit 82 gives mantissa 1 << 82 and exponent plus one. Otherwise the exponent passes through unchanged.
- R8: The mantissa is first shifted right by in_shift (0 to 127). Every nonzero shifted-out bit joins sticky for the rounding decision.
- R9: out_inexact is 1 when any bit below the target LSB (after the shift) or sticky is nonzero, whatever the mode.
- R10: in_cls encodes 0 number, 1 zero, 2 infinity, 3 NaN. Any class other than 0 passes sign, exponent, mantissa and class through unchanged, with out_inexact 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Block can take an operand |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 16 | Unbiased exponent, two's complement |
| in_mant | input | 83 | Mantissa, leading one at bit 82 |
| in_sticky | input | 1 | Nonzero bits already lost below the mantissa |
| in_cls | input | 2 | Class code |
| in_ctrl | input | 8 | Control byte: precision [7:6], mode [5:4] |
| in_shift | input | 7 | Right-shift distance before rounding |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | 16 | Result exponent |
| out_mant | output | 83 | Rounded mantissa |
| out_cls | output | 2 | Result class |
| out_inexact | output | 1 | Information was discarded |

## Verification
Random normalised mantissas are sent under every precision, mode and sign, with occasional shifts and sticky bits. They are compared against a bench model that decides rounding by comparing the discarded value with half an LSB, rather than by picking out individual bits.

Directed cases separate the tie-to-even path from the above-half path, for both an even and an odd kept LSB. They also show the sign dependence of the two directed modes and the carry that renormalises an all-ones mantissa. Further directed cases show that a shift alone can make a result inexact, and that precision code 11 behaves as extended. Backpressure checks confirm the result is held and a second operand is refused while the consumer stalls.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        MODE_NEAREST = 2'd0,
        MODE_TOZERO  = 2'd1,
        MODE_DOWN    = 2'd2,
        MODE_UP      = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        PREC_EXT  = 2'd0,
        PREC_SGL  = 2'd1,
        PREC_DBL  = 2'd2,
        PREC_EXT2 = 2'd3
    } prec_e;
endpackage

// File: rtl/rnd_rshift.sv
module rnd_rshift #(
    parameter int MW = 83,
    parameter int SW = 7
) (
    input  logic [MW-1:0] mant_i,
    input  logic          sticky_i,
    input  logic [SW-1:0] amt_i,
    output logic [MW-1:0] mant_o,
    output logic          sticky_o
);
    localparam int WIDE = 2 * MW;

    logic [WIDE-1:0] wide;

    always_comb begin
        wide     = {mant_i, {MW{1'b0}}} >> amt_i;
        mant_o   = wide[WIDE-1:MW];
        sticky_o = sticky_i | (|wide[MW-1:0]);
    end
endmodule

// File: rtl/rnd_core.sv
module rnd_core
    import rnd_pkg::*;
#(
    parameter int MW       = 83,
    parameter int EW       = 16,
    parameter int EXT_BITS = 64,
    parameter int DBL_BITS = 53,
    parameter int SGL_BITS = 24
) (
    input  logic          sign_i,
    input  logic [EW-1:0] exp_i,
    input  logic [MW-1:0] mant_i,
    input  logic          sticky_i,
    input  prec_e         prec_i,
    input  rmode_e        mode_i,
    output logic [MW-1:0] mant_o,
    output logic [EW-1:0] exp_o,
    output logic          inexact_o
);
    localparam int PW      = $clog2(MW);
    localparam int LSB_EXT = MW - EXT_BITS;
    localparam int LSB_DBL = MW - DBL_BITS;
    localparam int LSB_SGL = MW - SGL_BITS;

    logic [PW-1:0] lsb_pos;
    logic [MW-1:0] lsb_one, below, half, kept;
    logic          rbit, rest, odd, incr;
    logic [MW:0]   sum;

    always_comb begin
        unique case (prec_i)
            PREC_SGL: lsb_pos = PW'(LSB_SGL);
            PREC_DBL: lsb_pos = PW'(LSB_DBL);
            default:  lsb_pos = PW'(LSB_EXT);
        endcase
        lsb_one   = MW'(1) << lsb_pos;
        below     = lsb_one - MW'(1);
        half      = lsb_one >> 1;
        kept      = mant_i & ~below;
        rbit      = |(mant_i & half);
        rest      = (|(mant_i & (half - MW'(1)))) | sticky_i;
        odd       = |(mant_i & lsb_one);
        inexact_o = rbit | rest;
        unique case (mode_i)
            MODE_NEAREST: incr = rbit & (rest | odd);
            MODE_TOZERO:  incr = 1'b0;
            MODE_DOWN:    incr = sign_i & inexact_o;
            default:      incr = ~sign_i & inexact_o;
        endcase
        sum = {1'b0, kept} + (incr ? {1'b0, lsb_one} : {(MW+1){1'b0}});
        if (sum[MW]) begin
            mant_o = {1'b1, {(MW-1){1'b0}}};
            exp_o  = exp_i + EW'(1);
        end else begin
            mant_o = sum[MW-1:0];
            exp_o  = exp_i;
        end
    end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int MANT_W   = 83,
    parameter int EXP_W    = 16,
    parameter int SHIFT_W  = 7,
    parameter int EXT_BITS = 64,
    parameter int DBL_BITS = 53,
    parameter int SGL_BITS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sign,
    input  logic [EXP_W-1:0]   in_exp,
    input  logic [MANT_W-1:0]  in_mant,
    input  logic               in_sticky,
    input  logic [1:0]         in_cls,
    input  logic [7:0]         in_ctrl,
    input  logic [SHIFT_W-1:0] in_shift,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_sign,
    output logic [EXP_W-1:0]   out_exp,
    output logic [MANT_W-1:0]  out_mant,
    output logic [1:0]         out_cls,
    output logic               out_inexact
);
    typedef struct packed {
        logic              vld;
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic [1:0]        cls;
        logic              inexact;
    } res_t;

    res_t d_d, d_q;

    logic [MANT_W-1:0] sh_mant, rn_mant;
    logic              sh_sticky, rn_inexact;
    logic [EXP_W-1:0]  rn_exp;
    logic              accept;
    logic [3:0]        ctrl_unused;

    assign ctrl_unused = in_ctrl[3:0];

    rnd_rshift #(.MW(MANT_W), .SW(SHIFT_W)) u_shift (
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .amt_i    (in_shift),
        .mant_o   (sh_mant),
        .sticky_o (sh_sticky)
    );

    rnd_core #(
        .MW(MANT_W), .EW(EXP_W),
        .EXT_BITS(EXT_BITS), .DBL_BITS(DBL_BITS), .SGL_BITS(SGL_BITS)
    ) u_core (
        .sign_i    (in_sign),
        .exp_i     (in_exp),
        .mant_i    (sh_mant),
        .sticky_i  (sh_sticky),
        .prec_i    (prec_e'(in_ctrl[7:6])),
        .mode_i    (rmode_e'(in_ctrl[5:4])),
        .mant_o    (rn_mant),
        .exp_o     (rn_exp),
        .inexact_o (rn_inexact)
    );

    assign in_ready = ~d_q.vld | out_ready;
    assign accept   = in_valid & in_ready;

    always_comb begin
        d_d = d_q;
        if (accept) begin
            d_d.vld = 1'b1;
            d_d.sgn = in_sign;
            d_d.cls = in_cls;
            if (cls_e'(in_cls) == CLS_NUM) begin
                d_d.exp     = rn_exp;
                d_d.mant    = rn_mant;
                d_d.inexact = rn_inexact;
            end else begin
                d_d.exp     = in_exp;
                d_d.mant    = in_mant;
                d_d.inexact = 1'b0;
            end
        end else if (out_ready) begin
            d_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign out_valid   = d_q.vld;
    assign out_sign    = d_q.sgn;
    assign out_exp     = d_q.exp;
    assign out_mant    = d_q.mant;
    assign out_cls     = d_q.cls;
    assign out_inexact = d_q.inexact;
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int MW       = 83,
    parameter int EW       = 16,
    parameter int EXT_BITS = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [EW-1:0] out_exp,
    input logic [MW-1:0] out_mant,
    input logic [1:0]    out_cls,
    input logic          out_inexact
);
    localparam int LOW = MW - EXT_BITS;

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp));

    p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cls == 2'd0 |-> out_mant[LOW-1:0] == '0);

    p_special_exact_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cls != 2'd0 |-> !out_inexact);
endmodule

bind rnd_unit rnd_unit_chk #(.MW(MANT_W), .EW(EXP_W), .EXT_BITS(EXT_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_exp     (out_exp),
    .out_mant    (out_mant),
    .out_cls     (out_cls),
    .out_inexact (out_inexact)
);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 83;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic [1:0]    in_cls = 2'd0;
    logic [7:0]    in_ctrl = 8'h00;
    logic [6:0]    in_shift = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_sign;
    logic [EW-1:0] out_exp;
    logic [MW-1:0] out_mant;
    logic [1:0]    out_cls;
    logic          out_inexact;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
        .in_cls(in_cls), .in_ctrl(in_ctrl), .in_shift(in_shift),
        .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_cls(out_cls),
        .out_inexact(out_inexact)
    );

    function automatic void model(input logic s, input logic [EW-1:0] e,
                                  input logic [MW-1:0] m_in, input logic st_in,
                                  input logic [1:0] cls, input logic [7:0] ctrl,
                                  input int sh, output logic [EW-1:0] e_o,
                                  output logic [MW-1:0] m_o, output logic inex);
        logic [MW-1:0] m, disc, halfv;
        logic [MW:0] sum;
        logic st, up, tie, above;
        int lsb;
        m = m_in; st = st_in;
        if (cls != 2'd0) begin
            e_o = e; m_o = m_in; inex = 1'b0;
            return;
        end
        for (int i = 0; i < sh; i++) begin
            st = st | m[0];
            m = m >> 1;
        end
        case (ctrl[7:6])
            2'b01: lsb = 59;
            2'b10: lsb = 30;
            default: lsb = 19;
        endcase
        disc  = m % (MW'(1) << lsb);
        halfv = MW'(1) << (lsb - 1);
        inex  = (disc != 0) || st;
        tie   = (disc == halfv) && !st;
        above = (disc > halfv) || ((disc == halfv) && st);
        case (ctrl[5:4])
            2'b00: up = above || (tie && m[lsb]);
            2'b01: up = 1'b0;
            2'b10: up = s && inex;
            default: up = !s && inex;
        endcase
        sum = {1'b0, m - disc} + (up ? ((MW+1)'(1) << lsb) : '0);
        if (sum[MW]) begin
            m_o = MW'(1) << (MW - 1);
            e_o = e + 1;
        end else begin
            m_o = sum[MW-1:0];
            e_o = e;
        end
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic s, input logic [EW-1:0] e, input logic [MW-1:0] m,
                         input logic st, input logic [1:0] cls, input logic [7:0] ctrl,
                         input int sh);
        @(negedge clk);
        in_sign = s; in_exp = e; in_mant = m; in_sticky = st;
        in_cls = cls; in_ctrl = ctrl; in_shift = 7'(sh); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string req, input logic s, input logic [EW-1:0] e,
                       input logic [MW-1:0] m, input logic st, input logic [1:0] cls,
                       input logic [7:0] ctrl, input int sh);
        logic [EW-1:0] ee;
        logic [MW-1:0] em;
        logic ei;
        model(s, e, m, st, cls, ctrl, sh, ee, em, ei);
        drive(s, e, m, st, cls, ctrl, sh);
        chk(req, {out_valid, out_sign, out_cls, out_inexact, out_exp, out_mant},
                 {1'b1, s, cls, ei, ee, em});
    endtask

    localparam logic [MW-1:0] ONE = MW'(1) << (MW - 1);

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [MW-1:0] tmp;
        logic [EW-1:0] held_exp;
        logic [MW-1:0] held_mant;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {127'd0, out_valid}, 128'd0);
        chk("R2 ready when empty", {127'd0, in_ready}, 128'd1);

        // R4 tie with even LSB stays, odd LSB rounds up (extended, LSB bit 19)
        run("R4 tie even", 0, 16'd5, ONE | (MW'(1) << 18), 0, 0, 8'h00, 0);
        run("R4 tie odd", 0, 16'd5, ONE | (MW'(1) << 19) | (MW'(1) << 18), 0, 0, 8'h00, 0);
        run("R4 tie plus sticky", 0, 16'd5, ONE | (MW'(1) << 18), 1, 0, 8'h00, 0);
        run("R4 above half", 0, 16'd5, ONE | (MW'(3) << 17), 0, 0, 8'h00, 0);
        // R5 truncation
        run("R5 toward zero", 1, 16'd2, ONE | 83'h7ffff, 0, 0, 8'h10, 0);
        // R6 directed modes by sign
        run("R6 down negative", 1, 16'd0, ONE | 83'h1, 0, 0, 8'h20, 0);
        run("R6 down positive", 0, 16'd0, ONE | 83'h1, 0, 0, 8'h20, 0);
        run("R6 up positive", 0, 16'd0, ONE | 83'h1, 0, 0, 8'h30, 0);
        run("R6 up negative", 1, 16'd0, ONE | 83'h1, 0, 0, 8'h30, 0);
        // R7 carry renormalisation
        run("R7 carry out", 0, 16'h7ff0, {MW{1'b1}}, 0, 0, 8'h00, 0);
        run("R7 carry single", 1, 16'hfffe, {MW{1'b1}}, 0, 0, 8'h20, 0);
        // R3 precisions
        tmp = ONE | 83'h0123456789abcdef01234;
        run("R3 single", 0, 16'd1, tmp, 0, 0, 8'h40, 0);
        run("R3 double", 0, 16'd1, tmp, 0, 0, 8'h80, 0);
        run("R3 code 11 as extended", 0, 16'd1, tmp, 0, 0, 8'hc0, 0);
        // R8 shift alone makes it inexact; R9 exact case
        run("R8 shift folds sticky", 0, 16'd3, ONE | (MW'(1) << 20), 0, 0, 8'h10, 2);
        run("R8 shift large", 0, 16'd3, ONE, 0, 0, 8'h30, 100);
        run("R9 exact", 1, 16'd3, ONE | (MW'(1) << 19), 0, 0, 8'h00, 0);
        run("R9 sticky only", 1, 16'd3, ONE, 1, 0, 8'h10, 0);
        // R10 specials
        run("R10 nan", 1, 16'h7fff, {MW{1'b1}}, 1, 2'd3, 8'h30, 5);
        run("R10 inf", 0, 16'h1234, ONE | 83'h3, 1, 2'd2, 8'h00, 0);
        run("R10 zero", 1, 16'h0, 83'h5, 0, 2'd1, 8'h40, 0);

        // R2 backpressure
        out_ready = 1'b0;
        drive(1, 16'd9, ONE | 83'hfffff, 0, 0, 8'h00, 0);
        held_exp = out_exp; held_mant = out_mant;
        chk("R2 stalled valid", {126'd0, out_valid, in_ready}, {126'd0, 2'b10});
        drive(0, 16'd1, ONE, 0, 0, 8'h00, 0);
        chk("R2 held result", {out_valid, out_exp, out_mant}, {1'b1, held_exp, held_mant});
        out_ready = 1'b1;
        @(negedge clk);
        chk("R2 drains", {127'd0, out_valid}, 128'd0);

        // random traffic
        for (int k = 0; k < 400; k++) begin
            logic [MW-1:0] rm;
            logic [7:0] rc;
            int rs;
            rm = {$urandom, $urandom, $urandom} | ONE;
            if ($urandom_range(0, 7) == 0) rm = rm | ~((MW'(1) << $urandom_range(0, 40)) - 1);
            rc = {$urandom_range(0, 3) == 3 ? 2'd3 : 2'($urandom_range(0, 2)),
                  2'($urandom_range(0, 3)), 4'($urandom)};
            rs = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 90) : 0;
            run("R4 R5 R6 R9 random", 1'($urandom), 16'($urandom), rm,
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'd0,
                rc, rs);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule